// File: doc/BRIEF.md
# Biphase Multi-Waveform Function Generator

This block is a direct-digital-synthesis source that feeds two pin DACs, called channel A and channel B. A single phase accumulator is advanced by a signed frequency word on every clock. The top bits of the accumulator form a 9-bit phase. That phase is shaped into one of four waveforms: sine, triangle, sawtooth or square.

Channel B reads the same accumulator, but its phase is advanced by a programmable relative offset. This lets the pair drive quadrature, antiphase or any other fixed phase split. Both channels share one amplitude and one offset setting. The scaled result saturates at the top DAC code, and both DAC codes are registered on the same edge.

A frequency word with its top bit set is treated as negative, so the phase runs backwards. This gives a full signed 32-bit tuning range.

Top module: `fgen_biphase`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the accumulator clears to zero and both DAC outputs read 0.
- R2: At each rising edge out of reset, the accumulator adds `frq_i` modulo 2^32. The waveform phase is accumulator bits [31:23]. The DAC outputs registered at an edge are computed from the accumulator value held before that edge.
- R3: A frequency word with bit 31 set acts as a two's-complement negative step. For example, 0xFF80_0000 lowers the phase by exactly 1 on every cycle.
- R4: Select code 2 (sawtooth): the wave sample equals the phase p.
- R5: Select code 1 (triangle): the sample is 2p for p < 256 and 2(511 - p) for p >= 256.
- R6: Select code 3 (square): the sample is 511 for p < 256 and 0 for p >= 256.
- R7: Select code 0 (sine): let h = p mod 256 and b = min(255, floor(h(256 - h)/64)). The sample is 256 + b for p < 256 and 256 - b for p >= 256.
- R8: Each DAC code is min(511, floor(sample × amp / 512) + offset). With amplitude 0 the code equals the offset, and with offset 511 the code is 511.
- R9: Channel B uses phase (p + rel) mod 512, wrapping past 511.
- R10: Both outputs register on the same edge. With rel = 0, A and B are equal on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frq_i | input | 32 | Signed phase step per cycle |
| wave_sel_i | input | 2 | Waveform select: 0 sine, 1 triangle, 2 sawtooth, 3 square |
| amp_i | input | 9 | Amplitude multiplier (value/512) |
| ofs_i | input | 9 | Offset added after scaling |
| rel_i | input | 9 | Phase lead of channel B over channel A |
| dac_a_o | output | 9 | Registered DAC code, channel A |
| dac_b_o | output | 9 | Registered DAC code, channel B |

## Verification
On every cycle, the bound checker tests four things:
- the accumulator step, including the exact unit reverse step;
- saturation at offset 511;
- the pass-through of the offset at zero amplitude;
- the two-level square output, and the equality of the channels when the relative phase is zero.

The exact shapes of the triangle and the parabolic sine need the bench's scenarios. So do the wrap of the channel B phase past 511, the one-cycle lag between accumulator and outputs, and the reset values. Those scenarios are a fixed-phase table sweep over all four shapes, followed by forward and reverse accumulator runs that are checked against an independent model.

// File: rtl/fgen_pkg.sv
package fgen_pkg;

  parameter int CODE_W = 9;
  localparam int CODE_MAX = (1 << CODE_W) - 1;
  localparam int HALF     = 1 << (CODE_W - 1);
  localparam int DEPTH    = 1 << CODE_W;

  typedef logic [CODE_W-1:0] code_t;

  typedef enum logic [1:0] {
    WAVE_SINE = 2'd0,
    WAVE_TRI  = 2'd1,
    WAVE_SAW  = 2'd2,
    WAVE_SQR  = 2'd3
  } wave_e;

  // Parabolic half-cycle bump, centred on mid-scale.
  function automatic code_t sine_calc(input code_t p);
    int h;
    int bump;
    h    = int'(p[CODE_W-2:0]);
    bump = (h * (HALF - h)) >>> (CODE_W - 3);
    if (bump > HALF - 1) bump = HALF - 1;
    if (p[CODE_W-1]) return code_t'(HALF - bump);
    else             return code_t'(HALF + bump);
  endfunction

  function automatic code_t tri_calc(input code_t p);
    logic [CODE_W-2:0] low;
    low = p[CODE_W-1] ? ~p[CODE_W-2:0] : p[CODE_W-2:0];
    return {low, 1'b0};
  endfunction

  function automatic code_t sqr_calc(input code_t p);
    return p[CODE_W-1] ? '0 : '1;
  endfunction

  function automatic code_t scale_clamp(input code_t w, input code_t amp,
                                        input code_t ofs);
    logic [2*CODE_W-1:0] prod;
    logic [CODE_W:0]     sum;
    prod = {{CODE_W{1'b0}}, w} * {{CODE_W{1'b0}}, amp};
    sum  = {1'b0, prod[2*CODE_W-1:CODE_W]} + {1'b0, ofs};
    return sum[CODE_W] ? '1 : sum[CODE_W-1:0];
  endfunction

endpackage

// File: rtl/fgen_phase_acc.sv
module fgen_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] step_i,
  output logic [ACC_W-1:0] acc_o
);

  logic [ACC_W-1:0] acc_q;

  // Modular add; a step with the top bit set moves the phase backwards.
  always_ff @(posedge clk) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_q + step_i;
  end

  assign acc_o = acc_q;

endmodule

// File: rtl/fgen_sine_rom.sv
module fgen_sine_rom
  import fgen_pkg::*;
(
  input  code_t addr_i,
  output code_t data_o
);

  code_t rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign rom[i] = sine_calc(code_t'(i));
  end

  assign data_o = rom[addr_i];

endmodule

// File: rtl/fgen_wave_shaper.sv
module fgen_wave_shaper
  import fgen_pkg::*;
(
  input  code_t      phase_i,
  input  logic [1:0] sel_i,
  output code_t      wave_o
);

  code_t sine_w;

  fgen_sine_rom u_rom (
    .addr_i (phase_i),
    .data_o (sine_w)
  );

  always_comb begin
    unique case (wave_e'(sel_i))
      WAVE_SINE: wave_o = sine_w;
      WAVE_TRI:  wave_o = tri_calc(phase_i);
      WAVE_SAW:  wave_o = phase_i;
      WAVE_SQR:  wave_o = sqr_calc(phase_i);
      default:   wave_o = phase_i;
    endcase
  end

endmodule

// File: rtl/fgen_scale_clamp.sv
module fgen_scale_clamp
  import fgen_pkg::*;
(
  input  code_t wave_i,
  input  code_t amp_i,
  input  code_t ofs_i,
  output code_t code_o
);

  assign code_o = scale_clamp(wave_i, amp_i, ofs_i);

endmodule

// File: rtl/fgen_biphase.sv
module fgen_biphase
  import fgen_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] frq_i,
  input  logic [1:0]       wave_sel_i,
  input  logic [8:0]       amp_i,
  input  logic [8:0]       ofs_i,
  input  logic [8:0]       rel_i,
  output logic [8:0]       dac_a_o,
  output logic [8:0]       dac_b_o
);

  localparam int NCH = 2;

  logic [ACC_W-1:0] acc_q;
  code_t            phase_a;
  code_t            phase_b;
  code_t            phase_v [NCH];
  code_t            wave_v  [NCH];
  code_t            code_v  [NCH];
  code_t            dac_q   [NCH];

  fgen_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_i (frq_i),
    .acc_o  (acc_q)
  );

  assign phase_a    = acc_q[ACC_W-1 -: CODE_W];
  assign phase_b    = phase_a + rel_i;
  assign phase_v[0] = phase_a;
  assign phase_v[1] = phase_b;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    fgen_wave_shaper u_shape (
      .phase_i (phase_v[ch]),
      .sel_i   (wave_sel_i),
      .wave_o  (wave_v[ch])
    );

    fgen_scale_clamp u_scale (
      .wave_i (wave_v[ch]),
      .amp_i  (amp_i),
      .ofs_i  (ofs_i),
      .code_o (code_v[ch])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) dac_q[ch] <= '0;
      else        dac_q[ch] <= code_v[ch];
    end
  end

  assign dac_a_o = dac_q[0];
  assign dac_b_o = dac_q[1];

endmodule

// File: rtl/fgen_biphase_chk.sv
module fgen_biphase_chk #(
  parameter int ACC_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [ACC_W-1:0] frq,
  input logic [1:0]       wave_sel,
  input logic [8:0]       amp,
  input logic [8:0]       ofs,
  input logic [8:0]       rel,
  input logic [ACC_W-1:0] acc,
  input logic [8:0]       phase_a,
  input logic [8:0]       dac_a,
  input logic [8:0]       dac_b
);

  localparam logic [ACC_W-1:0] NEG_UNIT = ~(ACC_W'(1) << (ACC_W - 9)) + ACC_W'(1);

  logic seen_q;
  always_ff @(posedge clk) seen_q <= rst_n;

  a_r2_acc_step: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> acc == $past(acc) + $past(frq));

  a_r3_reverse_unit: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(frq) == NEG_UNIT) |-> phase_a == $past(phase_a) - 9'd1);

  a_r8_zero_amp: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(amp) == 9'd0) |-> (dac_a == $past(ofs) && dac_b == $past(ofs)));

  a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(ofs) == 9'd511) |-> (dac_a == 9'd511 && dac_b == 9'd511));

  a_r6_square_levels: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(wave_sel) == 2'd3 && $past(amp) == 9'd511 && $past(ofs) == 9'd0)
    |-> (dac_a == 9'd510 || dac_a == 9'd0));

  a_r10_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(rel) == 9'd0) |-> dac_a == dac_b);

endmodule

bind fgen_biphase fgen_biphase_chk #(.ACC_W(ACC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .frq      (frq_i),
  .wave_sel (wave_sel_i),
  .amp      (amp_i),
  .ofs      (ofs_i),
  .rel      (rel_i),
  .acc      (acc_q),
  .phase_a  (phase_a),
  .dac_a    (dac_a_o),
  .dac_b    (dac_b_o)
);

// File: tb/tb_fgen_biphase.sv
`timescale 1ns/1ps
module tb_fgen_biphase;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] frq = '0;
  logic [1:0]  sel = '0;
  logic [8:0]  amp = '0;
  logic [8:0]  ofs = '0;
  logic [8:0]  rel = '0;
  logic [8:0]  dac_a;
  logic [8:0]  dac_b;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  fgen_biphase dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .frq_i      (frq),
    .wave_sel_i (sel),
    .amp_i      (amp),
    .ofs_i      (ofs),
    .rel_i      (rel),
    .dac_a_o    (dac_a),
    .dac_b_o    (dac_b)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog (all reqs) actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  typedef struct packed {
    logic [1:0] s;
    logic [8:0] a, o, r, ea, eb;
  } vec_t;

  // Fixed phase (accumulator held at 0): A sees phase 0, B sees phase rel.
  localparam vec_t VEC [10] = '{
    '{2'd2, 9'd511, 9'd0,   9'd100, 9'd0,   9'd99 },  // R4
    '{2'd1, 9'd511, 9'd0,   9'd300, 9'd0,   9'd421},  // R5
    '{2'd3, 9'd511, 9'd0,   9'd256, 9'd510, 9'd0  },  // R6
    '{2'd0, 9'd511, 9'd0,   9'd64,  9'd255, 9'd447},  // R7
    '{2'd0, 9'd511, 9'd0,   9'd384, 9'd255, 9'd0  },  // R7
    '{2'd2, 9'd256, 9'd100, 9'd511, 9'd100, 9'd355},  // R8
    '{2'd2, 9'd511, 9'd300, 9'd400, 9'd300, 9'd511},  // R8 clamp
    '{2'd2, 9'd0,   9'd77,  9'd200, 9'd77,  9'd77 },  // R8 zero amp
    '{2'd1, 9'd128, 9'd10,  9'd128, 9'd10,  9'd74 },  // R9
    '{2'd0, 9'd511, 9'd0,   9'd0,   9'd255, 9'd255}   // R10
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int m_wave(input int s, input int p);
    int h, b;
    case (s)
      2: return p;
      1: return (p < 256) ? 2 * p : 2 * (511 - p);
      3: return (p < 256) ? 511 : 0;
      default: begin
        h = p % 256;
        b = h * (256 - h) / 64;
        if (b > 255) b = 255;
        return (p < 256) ? 256 + b : 256 - b;
      end
    endcase
  endfunction

  function automatic int m_out(input int s, input int p, input int a, input int o);
    int v;
    v = m_wave(s, p) * a / 512 + o;
    return (v > 511) ? 511 : v;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset dac_a", int'(dac_a), 0);
    chk("R1 reset dac_b", int'(dac_b), 0);
    rst_n = 1'b1;
  endtask

  task automatic sweep(input string tag, input logic [31:0] f, input int s,
                       input int a, input int o, input int r, input int n);
    logic [31:0] m;
    int pa, pb;
    frq = f; sel = 2'(s); amp = 9'(a); ofs = 9'(o); rel = 9'(r);
    do_reset();
    m = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pa = int'(m[31:23]);
      pb = (pa + r) % 512;
      chk({tag, " A"}, int'(dac_a), m_out(s, pa, a, o));
      chk({tag, " B"}, int'(dac_b), m_out(s, pb, a, o));
      m = m + f;
    end
  endtask

  initial begin
    // Table walk at fixed phase
    frq = '0; sel = 2'd2; amp = 9'd511; ofs = 9'd0; rel = 9'd0;
    do_reset();
    for (int i = 0; i < 10; i++) begin
      sel = VEC[i].s; amp = VEC[i].a; ofs = VEC[i].o; rel = VEC[i].r;
      @(negedge clk);
      chk($sformatf("R4-R10 vec%0d A", i), int'(dac_a), int'(VEC[i].ea));
      chk($sformatf("R4-R10 vec%0d B", i), int'(dac_b), int'(VEC[i].eb));
    end

    // R2 forward run, R5 triangle, R9 B phase wrap
    sweep("R2 R5 R9 tri fwd", 32'h0180_0005, 1, 511, 0, 500, 60);
    // R7 sine sweep
    sweep("R7 sine", 32'h0380_0000, 0, 400, 50, 128, 80);
    // R3 reverse unit step, R4 sawtooth
    sweep("R3 R4 saw rev", 32'hFF80_0000, 2, 511, 3, 7, 40);
    // R3 large negative step
    sweep("R3 big rev", 32'h9000_1234, 1, 300, 20, 77, 30);
    // R6 square antiphase, R8 clamp with offset
    sweep("R6 R8 square", 32'h0200_0000, 3, 300, 400, 256, 40);
    // R10 aligned channels under motion
    sweep("R10 sine aligned", 32'h0120_0000, 0, 511, 0, 0, 40);

    // R1 reset mid-run
    frq = 32'h0300_0000;
    repeat (5) @(negedge clk);
    do_reset();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule